// File: doc/BRIEF.md
# Interval Timer with Free-Running Timestamp

This block gives an operating system two time sources that share one tick strobe, a single-cycle clock-enable `tick_en` that is nominally 66.666 MHz. The first source is a 32-bit timestamp that counts every tick and that software can force back to zero. The second is an interval timer. It counts down from a programmed timeout, raises a sticky pending flag when it expires, and drives that flag straight onto an interrupt line. After an expiry it either reloads itself and keeps firing, or stops after the first expiry.

A single 32-bit control word sets the timer up. The two low bits of that word are control flags: bit 0 enables the timer and bit 1 selects single-shot operation. The same word, with its two low bits forced to zero, is the timeout in ticks, so the timeout can only be set in steps of four ticks. Software reaches all state through a simple register port. A write takes one cycle. A read is combinational from `rd_addr`. Word address 0 is the timestamp, address 1 is the control word, and address 2 is the status word, whose bit 0 is the pending flag. Address 3 reads as zero.

Top module: `ostimer_top`

## Requirements
- R1: After reset the timestamp, the control word and the status word all read 0, and `irq_o` is low.
- R2: The timestamp rises by exactly one at every clock edge where `tick_en` is high, and it holds its value when `tick_en` is low.
- R3: Any write to address 0 sets the timestamp to zero whatever the write data is, even when `tick_en` is high in the same cycle.
- R4: A write to address 1 stores the full word, and reading address 1 returns that word. Bit 0 is the enable flag, bit 1 is the single-shot flag, and bits [31:2] form the timeout.
- R5: With T equal to the control word with bits [1:0] cleared, the first tick after an enabling write loads T. The first expiry, which sets the pending flag, happens on the T-th tick after that loading tick. A T of 0 expires on every tick.
- R6: With enable set and single-shot clear, the timer reloads T on each expiry and expires again every T ticks.
- R7: With single-shot set, the timer expires once, hardware clears bit 0 of the control word, and no further expiry follows.
- R8: Writing 0 to address 1 stops the timer and clears its count, so no expiry follows.
- R9: A write to address 1 while the timer runs discards the running count. The timer does not count in the write cycle, and the next tick loads the new timeout.
- R10: The pending flag stays set until a write to address 2 with bit 0 set. A write to address 2 with bit 0 clear leaves the flag unchanged.
- R11: `irq_o` follows the pending flag. An expiry in the same cycle as a clear leaves the flag set.
- R12: Cycles with `tick_en` low neither advance the timer nor cause an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timebase strobe, one tick per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read word address |
| rd_data | output | 32 | Read data, combinational |
| irq_o | output | 1 | Interrupt, equal to the pending flag |

## Verification
The timer is run with a periodic timeout of 8 ticks and a single-shot timeout of 12 ticks. The interrupt is sampled one tick before and exactly on each expected expiry, which exposes any off-by-one in the load or expiry rule. Several patterns are checked for when the count advances: a tick burst interrupted by a long idle gap, a reload rewrite with `tick_en` high, and a status clear that lands on an expiry. Together these separate counting on `tick_en` from counting every cycle, and they show whether a write cycle suppresses the tick. The timestamp is checked across an idle gap and with a clear that collides with a tick.

// File: rtl/ost_pkg.sv
package ost_pkg;
    // Register word addresses
    localparam logic [1:0] ADDR_STAMP  = 2'd0;
    localparam logic [1:0] ADDR_RELOAD = 2'd1;
    localparam logic [1:0] ADDR_STATUS = 2'd2;

    // Control flags in the low bits of the reload word
    localparam int unsigned CTL_W       = 2;
    localparam int unsigned EN_BIT      = 0;
    localparam int unsigned ONESHOT_BIT = 1;

    // Status word
    localparam int unsigned PEND_BIT = 0;
endpackage

// File: rtl/ost_stamp.sv
module ost_stamp #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          clr,
    output logic [DW-1:0] stamp_o
);
    typedef struct packed {
        logic [DW-1:0] val;
    } stamp_st_t;

    stamp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.val = '0;
        end else if (tick_en) begin
            st_d.val = st_q.val + DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stamp_o = st_q.val;

    assert_stamp_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !clr) |=> (stamp_o == $past(stamp_o) + DW'(1)));

    assert_stamp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !clr) |=> $stable(stamp_o));

    assert_stamp_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (stamp_o == '0));
endmodule

// File: rtl/ost_tick.sv
module ost_tick
    import ost_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          reload_we,
    input  logic [DW-1:0] wr_data,
    input  logic          status_clr,
    output logic [DW-1:0] reload_o,
    output logic          pend_o
);
    typedef struct packed {
        logic [DW-1:0] reload;
        logic [DW-1:0] count;
        logic          armed;
        logic          pend;
    } tick_st_t;

    tick_st_t      st_d, st_q;
    logic [DW-1:0] timeout;
    logic          expire;

    // Timeout with the flag bits forced to zero
    assign timeout = {st_q.reload[DW-1:CTL_W], {CTL_W{1'b0}}};

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (reload_we) begin
            st_d.reload = wr_data;
            st_d.armed  = wr_data[EN_BIT];
            if (!wr_data[EN_BIT]) st_d.count = '0;
        end else if (tick_en && st_q.reload[EN_BIT]) begin
            if (st_q.armed) begin
                st_d.count = timeout;
                st_d.armed = 1'b0;
            end else if (st_q.count <= DW'(1)) begin
                expire = 1'b1;
                if (st_q.reload[ONESHOT_BIT]) begin
                    st_d.reload[EN_BIT] = 1'b0;
                    st_d.count          = '0;
                end else begin
                    st_d.count = timeout;
                end
            end else begin
                st_d.count = st_q.count - DW'(1);
            end
        end
        if (status_clr) st_d.pend = 1'b0;
        if (expire)     st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reload_o = st_q.reload;
    assign pend_o   = st_q.pend;

    assert_reload_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload_we && !tick_en) |=> $stable(reload_o));

    assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pend_o) && $past(reload_o[ONESHOT_BIT]) && !$past(reload_we))
        |-> !reload_o[EN_BIT]);

    assert_zero_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_we && wr_data == '0) |=> (reload_o == '0));

    assert_pend_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !status_clr) |=> pend_o);

    assert_pend_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clr && !tick_en) |=> !pend_o);

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !pend_o) |=> !pend_o);
endmodule

// File: rtl/ost_decode.sv
module ost_decode
    import ost_pkg::*;
#(
    parameter int unsigned DW     = 32,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_lsb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DW-1:0]     stamp,
    input  logic [DW-1:0]     reload,
    input  logic              pend,
    output logic              stamp_clr,
    output logic              reload_we,
    output logic              status_clr,
    output logic [DW-1:0]     rd_data
);
    localparam logic [ADDR_W-1:0] A_STAMP  = ADDR_W'(ADDR_STAMP);
    localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(ADDR_RELOAD);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADDR_STATUS);

    always_comb begin
        stamp_clr  = wr_en && (wr_addr == A_STAMP);
        reload_we  = wr_en && (wr_addr == A_RELOAD);
        status_clr = wr_en && (wr_addr == A_STATUS) && wr_lsb;
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_STAMP:  rd_data = stamp;
            A_RELOAD: rd_data = reload;
            A_STATUS: rd_data[PEND_BIT] = pend;
            default:  rd_data = '0;
        endcase
    end

    always_comb begin
        assert_one_strobe_R4: assert (!(reload_we && (stamp_clr || status_clr)));
    end
endmodule

// File: rtl/ostimer_top.sv
module ostimer_top #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_o
);
    logic              stamp_clr, reload_we, status_clr, pend;
    logic [DATA_W-1:0] stamp, reload;

    ost_decode #(.DW(DATA_W), .ADDR_W(ADDR_W)) u_decode (
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_lsb     (wr_data[0]),
        .rd_addr    (rd_addr),
        .stamp      (stamp),
        .reload     (reload),
        .pend       (pend),
        .stamp_clr  (stamp_clr),
        .reload_we  (reload_we),
        .status_clr (status_clr),
        .rd_data    (rd_data)
    );

    ost_stamp #(.DW(DATA_W)) u_stamp (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .clr     (stamp_clr),
        .stamp_o (stamp)
    );

    ost_tick #(.DW(DATA_W)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .reload_we  (reload_we),
        .wr_data    (wr_data),
        .status_clr (status_clr),
        .reload_o   (reload),
        .pend_o     (pend)
    );

    assign irq_o = pend;

    assert_irq_needs_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(tick_en));
endmodule

// File: tb/tb_ostimer_top.sv
module tb_ostimer_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_en, wr_en;
    logic [1:0]  wr_addr, rd_addr;
    logic [31:0] wr_data, rd_data;
    logic        irq_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ostimer_top dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic tk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; tick_en = tk;
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            tick_en = 1'b1;
            repeat (n) @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    task automatic chk_rd(input logic [1:0] a, input logic [31:0] exp, input string req);
        rd_addr = a;
        #1;
        n_run++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s: addr %0d read %h expected %h", req, a, rd_data, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string req);
        n_run++;
        if (irq_o !== exp) begin
            n_fail++;
            $display("FAIL %s: irq_o %b expected %b", req, irq_o, exp);
        end
    endtask

    task automatic normalize();
        wr(2'd1, 32'h0, 1'b0);
        wr(2'd2, 32'h1, 1'b0);
    endtask

    task automatic t_reset();
        chk_rd(2'd0, 32'h0, "R1");
        chk_rd(2'd1, 32'h0, "R1");
        chk_rd(2'd2, 32'h0, "R1");
        chk_irq(1'b0, "R1");
    endtask

    task automatic t_stamp();
        wr(2'd0, 32'h5, 1'b0);          // data ignored: clears (R3)
        chk_rd(2'd0, 32'h0, "R3");
        ticks(10);
        chk_rd(2'd0, 32'd10, "R2");
        repeat (3) @(negedge clk);
        chk_rd(2'd0, 32'd10, "R2 hold");
        wr(2'd0, 32'h0, 1'b1);          // clear beats tick
        chk_rd(2'd0, 32'h0, "R3 vs tick");
    endtask

    task automatic t_periodic();
        wr(2'd1, 32'hA5A5_A5A4, 1'b0);
        chk_rd(2'd1, 32'hA5A5_A5A4, "R4");
        wr(2'd1, 32'h9, 1'b0);          // T=8, enabled, periodic
        chk_rd(2'd1, 32'h9, "R4");
        ticks(8);
        chk_irq(1'b0, "R5 early");
        ticks(1);
        chk_irq(1'b1, "R5 expiry");
        chk_rd(2'd2, 32'h1, "R11");
        wr(2'd2, 32'h1, 1'b0);
        chk_irq(1'b0, "R10 clear");
        ticks(7);
        chk_irq(1'b0, "R6 early");
        ticks(1);
        chk_irq(1'b1, "R6 period");
        wr(2'd2, 32'h0, 1'b0);
        chk_irq(1'b1, "R10 zero write");
        wr(2'd2, 32'h1, 1'b0);
        ticks(7);
        chk_irq(1'b0, "R11 early");
        wr(2'd2, 32'h1, 1'b1);          // clear collides with expiry
        chk_irq(1'b1, "R11 expiry wins");
    endtask

    task automatic t_oneshot();
        normalize();
        wr(2'd1, 32'hF, 1'b0);          // T=12, single-shot
        ticks(12);
        chk_irq(1'b0, "R7 early");
        ticks(1);
        chk_irq(1'b1, "R7 expiry");
        chk_rd(2'd1, 32'hE, "R7 enable cleared");
        wr(2'd2, 32'h1, 1'b0);
        ticks(40);
        chk_irq(1'b0, "R7 no repeat");
    endtask

    task automatic t_zero();
        normalize();
        wr(2'd1, 32'h9, 1'b0);
        ticks(5);
        wr(2'd1, 32'h0, 1'b0);
        chk_rd(2'd1, 32'h0, "R8");
        ticks(30);
        chk_irq(1'b0, "R8 stopped");
    endtask

    task automatic t_restart();
        normalize();
        wr(2'd1, 32'h21, 1'b0);         // T=32
        ticks(20);
        wr(2'd1, 32'h9, 1'b1);          // rewrite, tick suppressed
        ticks(8);
        chk_irq(1'b0, "R9 early");
        ticks(1);
        chk_irq(1'b1, "R9 new timeout");
        wr(2'd2, 32'h1, 1'b0);
        ticks(4);
        repeat (50) @(negedge clk);
        chk_irq(1'b0, "R12 idle gap");
        ticks(3);
        chk_irq(1'b0, "R12 early");
        ticks(1);
        chk_irq(1'b1, "R12 resumed");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run incomplete, expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0;
        wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stamp();
        t_periodic();
        t_oneshot();
        t_zero();
        t_restart();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule